// File: doc/BRIEF.md
# Indexed Interrupt Redirection Register File

This block is the register side of an interrupt router. A bus master sees a 4 KB memory region. Two words in that region matter. The first is a selector that holds an 8-bit register number. The second is a data window that reads and writes whichever internal register the selector names. Behind the window sit:

- an identifier register;
- two read-only informational registers;
- a table of per-input redirection entries. Each entry is 64 bits wide and split into a low and a high 32-bit half.

The block decodes every entry into separate output fields for the delivery logic beside it: vector, delivery mode, destination mode, delivery status, polarity, remote IRR, trigger mode, mask and destination. It also emits a one-cycle service strobe whenever software rewrites any entry half.

Each bus request is presented for one cycle. A request that falls inside the region gets a response in the next cycle, carrying read data and an error flag. Illegal accesses are flagged and leave all state untouched. Requests outside the region get no response at all.

Top module: `ioredir_top`

## Requirements
- R1: After reset every entry has mask set (low bit 16) and all other fields zero, the selector reads 0 and the identifier is 0.
- R2: A 4-byte write at region offset 0x00 loads the selector from write bits 7:0. A read at offset 0x00 returns the selector zero-extended.
- R3: With selector 0, a window (offset 0x10) write takes the identifier from bits 27:24, and a window read returns it in bits 27:24 with all other bits zero. With selector 2 the window reads the identifier in bits 27:24 as well.
- R4: With selector 1 the window reads the highest entry number (23) in bits 23:16 and version code 0x11 in bits 7:0. Window writes with selector 1 or 2 change nothing and raise no error.
- R5: Entry n has its low half at selector 0x10+2n and its high half at selector 0x11+2n. The low half holds vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, polarity 13, remote IRR 14, trigger 15 and mask 16. The high half holds the destination in 31:24. All other bits read zero.
- R6: Delivery status (bit 12) and remote IRR (bit 14) cannot be changed from the bus.
- R7: `svc_pulse` is high for exactly the one cycle after an accepted write to any entry half, and never after other writes.
- R8: A write whose size code is not 2 (4 bytes) or whose address bits 3:0 are not zero is flagged in `err` and changes nothing.
- R9: Size codes 0, 1 and 2 select 1, 2 and 4 byte reads. A read returns the aligned word shifted right by 8 times address bits 1:0, truncated to the access size.
- R10: A read that crosses a 32-bit boundary, or that uses size code 3, returns zero with `err` set.
- R11: A selector in 3..0x0F or at or above 0x40 makes a window read return zero with `err`, and a window write flag `err` without changing anything. Word offsets other than 0x00 and 0x10 behave the same way.
- R12: A request with address bits 31:12 equal to the base (0xFEC00000) gets `rsp_valid` one cycle later, and only address bits 7:0 are decoded. Any other request gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 32 | Byte address |
| size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = illegal |
| wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for an in-region request |
| rdata | output | 32 | Read data (zero for writes and errors) |
| err | output | 1 | Access was illegal |
| svc_pulse | output | 1 | An entry half was rewritten |
| ent_vector | output | 192 | Vector per entry, 8 bits each |
| ent_dlvmode | output | 72 | Delivery mode per entry, 3 bits each |
| ent_dstmode | output | 24 | Destination mode per entry |
| ent_dlvstat | output | 24 | Delivery status per entry |
| ent_polarity | output | 24 | Polarity per entry |
| ent_rirr | output | 24 | Remote IRR per entry |
| ent_trigger | output | 24 | Trigger mode per entry |
| ent_mask | output | 24 | Mask per entry |
| ent_dest | output | 192 | Destination per entry, 8 bits each |

## Verification
The hardest states to reach involve the selector. An entry, the identifier, or an undefined register is reachable only through a prior selector write. A fault in the selector-to-target decode therefore shows up only when a later window access lands on a specific target.

The stimulus table steers the selector to each class of target before the window access under test:

- the last entry's high half;
- the first index past the table;
- a hole below the table;
- both informational registers.

Reads of the same entry at every byte offset and size then expose the shift and boundary rules.

// File: rtl/ioredir_pkg.sv
package ioredir_pkg;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       trig;
    logic       rirr;
    logic       pol;
    logic       dstat;
    logic       dstmode;
    logic [2:0] dlvmode;
    logic [7:0] vector;
  } redir_t;

  typedef enum logic [2:0] {
    TGT_ID,
    TGT_VER,
    TGT_ARB,
    TGT_LO,
    TGT_HI,
    TGT_NONE
  } tgt_e;

  localparam logic [7:0] SEL_TABLE = 8'h10;

  function automatic redir_t redir_reset();
    redir_t e;
    e      = '0;
    e.mask = 1'b1;
    return e;
  endfunction

  function automatic logic [31:0] redir_lo_word(redir_t e);
    return {15'd0, e.mask, e.trig, e.rirr, e.pol, e.dstat,
            e.dstmode, e.dlvmode, e.vector};
  endfunction

  function automatic logic [31:0] redir_hi_word(redir_t e);
    return {e.dest, 24'd0};
  endfunction

  function automatic redir_t redir_lo_write(redir_t e, logic [31:0] w);
    redir_t n;
    n         = e;
    n.vector  = w[7:0];
    n.dlvmode = w[10:8];
    n.dstmode = w[11];
    n.pol     = w[13];
    n.trig    = w[15];
    n.mask    = w[16];
    return n;
  endfunction

  function automatic redir_t redir_hi_write(redir_t e, logic [31:0] w);
    redir_t n;
    n      = e;
    n.dest = w[31:24];
    return n;
  endfunction

endpackage

// File: rtl/ioredir_rst_sync.sv
module ioredir_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/ioredir_entry.sv
module ioredir_entry
  import ioredir_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lo_we,
  input  logic        hi_we,
  input  logic [31:0] wdata,
  output redir_t      entry
);
  redir_t entry_q, entry_d;

  always_comb begin
    entry_d = entry_q;
    if (lo_we) entry_d = redir_lo_write(entry_q, wdata);
    if (hi_we) entry_d = redir_hi_write(entry_q, wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              entry_q <= redir_reset();
    else if (lo_we || hi_we) entry_q <= entry_d;
  end

  assign entry = entry_q;
endmodule

// File: rtl/ioredir_bus_dec.sv
module ioredir_bus_dec
  import ioredir_pkg::*;
#(
  parameter logic [31:0] BASE        = 32'hFEC0_0000,
  parameter int          NUM_ENTRIES = 24,
  parameter int          ENT_W       = 5
) (
  input  logic             req,
  input  logic             we,
  input  logic [31:0]      addr,
  input  logic [1:0]       size,
  input  logic [7:0]       sel_q,
  output logic             hit,
  output logic             sel_wr,
  output logic             win_wr,
  output logic             rd_sel,
  output logic             rd_win,
  output tgt_e             tgt,
  output logic [ENT_W-1:0] ent_num,
  output logic             bad
);
  localparam int SEL_END = 32'(SEL_TABLE) + 2 * NUM_ENTRIES;

  logic [7:0] off;
  logic       wr_shape_ok;
  logic       is_sel_off;
  logic       is_win_off;
  logic       rd_cross;
  logic [2:0] last_byte;
  logic [7:0] rel;

  assign off        = addr[7:0];
  assign hit        = req && (addr[31:12] == BASE[31:12]);
  assign is_sel_off = (off[7:2] == 6'h00);
  assign is_win_off = (off[7:2] == 6'h04);

  // target selected by the current selector value
  always_comb begin
    rel     = sel_q - SEL_TABLE;
    ent_num = rel[ENT_W:1];
    if (sel_q == 8'h00)                                  tgt = TGT_ID;
    else if (sel_q == 8'h01)                             tgt = TGT_VER;
    else if (sel_q == 8'h02)                             tgt = TGT_ARB;
    else if (sel_q >= SEL_TABLE && 32'(sel_q) < SEL_END) tgt = sel_q[0] ? TGT_HI : TGT_LO;
    else                                                 tgt = TGT_NONE;
  end

  always_comb begin
    wr_shape_ok = (size == 2'd2) && (addr[3:0] == 4'h0);
    last_byte   = {1'b0, addr[1:0]} + ((3'd1 << size) - 3'd1);
    rd_cross    = (size == 2'd3) || (last_byte > 3'd3);

    sel_wr = 1'b0;
    win_wr = 1'b0;
    rd_sel = 1'b0;
    rd_win = 1'b0;
    bad    = 1'b0;
    if (hit) begin
      if (we) begin
        if (!wr_shape_ok || !(is_sel_off || is_win_off)) bad = 1'b1;
        else if (is_sel_off)                             sel_wr = 1'b1;
        else if (tgt == TGT_NONE)                        bad = 1'b1;
        else                                             win_wr = 1'b1;
      end else begin
        if (rd_cross || !(is_sel_off || is_win_off)) bad = 1'b1;
        else if (is_sel_off)                         rd_sel = 1'b1;
        else if (tgt == TGT_NONE)                    bad = 1'b1;
        else                                         rd_win = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ioredir_top.sv
module ioredir_top
  import ioredir_pkg::*;
#(
  parameter logic [31:0] BASE        = 32'hFEC0_0000,
  parameter int          NUM_ENTRIES = 24,
  parameter int          ID_W        = 4,
  parameter logic [7:0]  VERSION     = 8'h11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic                     we,
  input  logic [31:0]              addr,
  input  logic [1:0]               size,
  input  logic [31:0]              wdata,
  output logic                     rsp_valid,
  output logic [31:0]              rdata,
  output logic                     err,
  output logic                     svc_pulse,
  output logic [NUM_ENTRIES*8-1:0] ent_vector,
  output logic [NUM_ENTRIES*3-1:0] ent_dlvmode,
  output logic [NUM_ENTRIES-1:0]   ent_dstmode,
  output logic [NUM_ENTRIES-1:0]   ent_dlvstat,
  output logic [NUM_ENTRIES-1:0]   ent_polarity,
  output logic [NUM_ENTRIES-1:0]   ent_rirr,
  output logic [NUM_ENTRIES-1:0]   ent_trigger,
  output logic [NUM_ENTRIES-1:0]   ent_mask,
  output logic [NUM_ENTRIES*8-1:0] ent_dest
);
  localparam int         ENT_W   = $clog2(NUM_ENTRIES);
  localparam logic [7:0] MAX_IDX = 8'(NUM_ENTRIES - 1);

  logic             rst_sync_n;
  logic             hit, sel_wr, win_wr, rd_sel, rd_win, bad;
  tgt_e             tgt;
  logic [ENT_W-1:0] ent_num;

  logic [7:0]       sel_q, sel_d;
  logic [ID_W-1:0]  id_q, id_d;
  logic             rsp_valid_q, rsp_valid_d;
  logic [31:0]      rdata_q, rdata_d;
  logic             err_q, err_d;
  logic             svc_q, svc_d;

  redir_t           entries [NUM_ENTRIES];
  logic [31:0]      word;
  logic [31:0]      shifted;
  logic [7:0]       id8;

  ioredir_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ioredir_bus_dec #(
    .BASE        (BASE),
    .NUM_ENTRIES (NUM_ENTRIES),
    .ENT_W       (ENT_W)
  ) u_dec (
    .req     (req),
    .we      (we),
    .addr    (addr),
    .size    (size),
    .sel_q   (sel_q),
    .hit     (hit),
    .sel_wr  (sel_wr),
    .win_wr  (win_wr),
    .rd_sel  (rd_sel),
    .rd_win  (rd_win),
    .tgt     (tgt),
    .ent_num (ent_num),
    .bad     (bad)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    logic lo_we, hi_we;
    assign lo_we = win_wr && (tgt == TGT_LO) && (ent_num == ENT_W'(g));
    assign hi_we = win_wr && (tgt == TGT_HI) && (ent_num == ENT_W'(g));

    ioredir_entry u_entry (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .lo_we (lo_we),
      .hi_we (hi_we),
      .wdata (wdata),
      .entry (entries[g])
    );

    assign ent_vector[g*8 +: 8]  = entries[g].vector;
    assign ent_dlvmode[g*3 +: 3] = entries[g].dlvmode;
    assign ent_dstmode[g]        = entries[g].dstmode;
    assign ent_dlvstat[g]        = entries[g].dstat;
    assign ent_polarity[g]       = entries[g].pol;
    assign ent_rirr[g]           = entries[g].rirr;
    assign ent_trigger[g]        = entries[g].trig;
    assign ent_mask[g]           = entries[g].mask;
    assign ent_dest[g*8 +: 8]    = entries[g].dest;
  end

  assign id8 = 8'(id_q);

  // window read value for the selected target
  always_comb begin
    case (tgt)
      TGT_ID:  word = {id8, 24'd0};
      TGT_VER: word = {8'd0, MAX_IDX, 8'd0, VERSION};
      TGT_ARB: word = {4'd0, id8[3:0], 24'd0};
      TGT_LO:  word = redir_lo_word(entries[ent_num]);
      TGT_HI:  word = redir_hi_word(entries[ent_num]);
      default: word = 32'd0;
    endcase
    if (rd_sel) word = {24'd0, sel_q};
  end

  // next state
  always_comb begin
    sel_d       = sel_q;
    id_d        = id_q;
    rsp_valid_d = hit;
    err_d       = bad;
    svc_d       = win_wr && (tgt == TGT_LO || tgt == TGT_HI);
    rdata_d     = 32'd0;
    shifted     = word >> {addr[1:0], 3'b000};

    if (sel_wr)                     sel_d = wdata[7:0];
    if (win_wr && (tgt == TGT_ID))  id_d  = wdata[24 +: ID_W];
    if (rd_sel || rd_win) begin
      case (size)
        2'd0:    rdata_d = {24'd0, shifted[7:0]};
        2'd1:    rdata_d = {16'd0, shifted[15:0]};
        default: rdata_d = shifted;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sel_q       <= 8'd0;
      id_q        <= '0;
      rsp_valid_q <= 1'b0;
      rdata_q     <= 32'd0;
      err_q       <= 1'b0;
      svc_q       <= 1'b0;
    end else begin
      if (sel_wr) sel_q <= sel_d;
      if (win_wr) id_q  <= id_d;
      rsp_valid_q <= rsp_valid_d;
      rdata_q     <= rdata_d;
      err_q       <= err_d;
      svc_q       <= svc_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rdata     = rdata_q;
  assign err       = err_q;
  assign svc_pulse = svc_q;
endmodule

// File: rtl/ioredir_chk.sv
module ioredir_chk #(
  parameter logic [31:0] BASE        = 32'hFEC0_0000,
  parameter int          NUM_ENTRIES = 24
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req,
  input logic                   we,
  input logic [31:0]            addr,
  input logic [1:0]             size,
  input logic                   rsp_valid,
  input logic [31:0]            rdata,
  input logic                   err,
  input logic                   svc_pulse,
  input logic [NUM_ENTRIES-1:0] ent_dlvstat,
  input logic [NUM_ENTRIES-1:0] ent_rirr
);
  logic in_region;
  assign in_region = req && (addr[31:12] == BASE[31:12]);

  assert_rsp_follows_hit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(in_region));

  assert_no_rsp_outside_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !in_region) |=> !rsp_valid);

  assert_err_has_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> rsp_valid);

  assert_misaligned_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_region && we && addr[3:0] != 4'h0) |=> (err && !svc_pulse));

  assert_svc_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    svc_pulse |-> $past(in_region && we));

  assert_cross_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_region && !we && size == 2'd1 && addr[1:0] == 2'd3) |=> (err && rdata == 32'd0));

  assert_ro_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_region && we) |=> ($stable(ent_dlvstat) && $stable(ent_rirr)));
endmodule

bind ioredir_top ioredir_chk #(
  .BASE        (BASE),
  .NUM_ENTRIES (NUM_ENTRIES)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req         (req),
  .we          (we),
  .addr        (addr),
  .size        (size),
  .rsp_valid   (rsp_valid),
  .rdata       (rdata),
  .err         (err),
  .svc_pulse   (svc_pulse),
  .ent_dlvstat (ent_dlvstat),
  .ent_rirr    (ent_rirr)
);

// File: tb/ioredir_top_tb.sv
module ioredir_top_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          N          = 24;
  localparam logic [31:0] BASE       = 32'hFEC0_0000;

  typedef struct packed {
    logic        we;
    logic [11:0] off;
    logic [1:0]  size;
    logic [31:0] wd;
    logic        err;
    logic [31:0] rd;
    logic        svc;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 12'h000, 2'd2, 32'h0000_0001, 1'b0, 32'h0000_0000, 1'b0}, // R2 sel=1
    '{1'b0, 12'h010, 2'd2, 32'h0,         1'b0, 32'h0017_0011, 1'b0}, // R4 version
    '{1'b1, 12'h000, 2'd2, 32'h0000_0010, 1'b0, 32'h0,         1'b0}, // sel entry0 lo
    '{1'b0, 12'h010, 2'd2, 32'h0,         1'b0, 32'h0001_0000, 1'b0}, // R1 masked
    '{1'b1, 12'h010, 2'd2, 32'hFFFF_FFFF, 1'b0, 32'h0,         1'b1}, // R7 svc
    '{1'b0, 12'h010, 2'd2, 32'h0,         1'b0, 32'h0001_AFFF, 1'b0}, // R5 R6
    '{1'b0, 12'h011, 2'd0, 32'h0,         1'b0, 32'h0000_00AF, 1'b0}, // R9 byte1
    '{1'b0, 12'h012, 2'd1, 32'h0,         1'b0, 32'h0000_0001, 1'b0}, // R9 half
    '{1'b0, 12'h013, 2'd1, 32'h0,         1'b1, 32'h0,         1'b0}, // R10 cross
    '{1'b0, 12'h000, 2'd2, 32'h0,         1'b0, 32'h0000_0010, 1'b0}, // R2 read sel
    '{1'b1, 12'h000, 2'd2, 32'h0000_0011, 1'b0, 32'h0,         1'b0}, // sel entry0 hi
    '{1'b1, 12'h010, 2'd2, 32'hA512_3456, 1'b0, 32'h0,         1'b1}, // R7 hi write
    '{1'b0, 12'h010, 2'd2, 32'h0,         1'b0, 32'hA500_0000, 1'b0}, // R5 dest
    '{1'b1, 12'h014, 2'd2, 32'hFFFF_FFFF, 1'b1, 32'h0,         1'b0}, // R8 misaligned
    '{1'b1, 12'h010, 2'd0, 32'hFFFF_FFFF, 1'b1, 32'h0,         1'b0}, // R8 narrow
    '{1'b0, 12'h010, 2'd2, 32'h0,         1'b0, 32'hA500_0000, 1'b0}, // R8 unchanged
    '{1'b1, 12'h000, 2'd2, 32'h0000_0002, 1'b0, 32'h0,         1'b0}, // sel arb
    '{1'b1, 12'h010, 2'd2, 32'hFFFF_FFFF, 1'b0, 32'h0,         1'b0}, // R4 ignored
    '{1'b0, 12'h010, 2'd2, 32'h0,         1'b0, 32'h0000_0000, 1'b0}, // R4 arb id0
    '{1'b1, 12'h000, 2'd2, 32'h0000_0000, 1'b0, 32'h0,         1'b0}, // sel id
    '{1'b1, 12'h010, 2'd2, 32'hFA00_0000, 1'b0, 32'h0,         1'b0}, // R3 id=A
    '{1'b0, 12'h010, 2'd2, 32'h0,         1'b0, 32'h0A00_0000, 1'b0}, // R3 read id
    '{1'b1, 12'h000, 2'd2, 32'h0000_0002, 1'b0, 32'h0,         1'b0}, // sel arb
    '{1'b0, 12'h010, 2'd2, 32'h0,         1'b0, 32'h0A00_0000, 1'b0}, // R3 arb id
    '{1'b1, 12'h000, 2'd2, 32'h0000_0005, 1'b0, 32'h0,         1'b0}, // sel hole
    '{1'b0, 12'h010, 2'd2, 32'h0,         1'b1, 32'h0,         1'b0}, // R11 hole read
    '{1'b1, 12'h010, 2'd2, 32'h1234_5678, 1'b1, 32'h0,         1'b0}, // R11 hole write
    '{1'b1, 12'h000, 2'd2, 32'h0000_0040, 1'b0, 32'h0,         1'b0}, // sel past table
    '{1'b0, 12'h010, 2'd2, 32'h0,         1'b1, 32'h0,         1'b0}, // R11 past end
    '{1'b1, 12'h000, 2'd2, 32'h0000_003F, 1'b0, 32'h0,         1'b0}, // sel entry23 hi
    '{1'b1, 12'h010, 2'd2, 32'h7700_0000, 1'b0, 32'h0,         1'b1}, // R5 last entry
    '{1'b0, 12'h010, 2'd2, 32'h0,         1'b0, 32'h7700_0000, 1'b0}, // R5 read back
    '{1'b0, 12'h020, 2'd2, 32'h0,         1'b1, 32'h0,         1'b0}, // R11 bad offset rd
    '{1'b1, 12'h020, 2'd2, 32'h1,         1'b1, 32'h0,         1'b0}, // R11 bad offset wr
    '{1'b0, 12'h010, 2'd3, 32'h0,         1'b1, 32'h0,         1'b0}, // R10 size 3
    '{1'b0, 12'h000, 2'd0, 32'h0,         1'b0, 32'h0000_003F, 1'b0}, // R9 byte0 sel
    '{1'b1, 12'h000, 2'd2, 32'h0000_0001, 1'b0, 32'h0,         1'b0}, // sel version
    '{1'b1, 12'h010, 2'd2, 32'hFFFF_FFFF, 1'b0, 32'h0,         1'b0}, // R4 ignored
    '{1'b0, 12'h010, 2'd2, 32'h0,         1'b0, 32'h0017_0011, 1'b0}, // R4 unchanged
    '{1'b0, 12'h310, 2'd2, 32'h0,         1'b0, 32'h0017_0011, 1'b0}  // R12 low 8 bits
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req;
  logic             we;
  logic [31:0]      addr;
  logic [1:0]       size;
  logic [31:0]      wdata;
  logic             rsp_valid;
  logic [31:0]      rdata;
  logic             err;
  logic             svc_pulse;
  logic [N*8-1:0]   ent_vector;
  logic [N*3-1:0]   ent_dlvmode;
  logic [N-1:0]     ent_dstmode, ent_dlvstat, ent_polarity, ent_rirr;
  logic [N-1:0]     ent_trigger, ent_mask;
  logic [N*8-1:0]   ent_dest;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ioredir_top dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .size(size),
    .wdata(wdata), .rsp_valid(rsp_valid), .rdata(rdata), .err(err),
    .svc_pulse(svc_pulse), .ent_vector(ent_vector), .ent_dlvmode(ent_dlvmode),
    .ent_dstmode(ent_dstmode), .ent_dlvstat(ent_dlvstat),
    .ent_polarity(ent_polarity), .ent_rirr(ent_rirr),
    .ent_trigger(ent_trigger), .ent_mask(ent_mask), .ent_dest(ent_dest)
  );

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // drive one request for one edge, sample the response just after it
  task automatic access(input logic w, input logic [31:0] a, input logic [1:0] s,
                        input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; size = s; wdata = d;
    @(posedge clk);
    #1;
    req = 1'b0; we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    req = 1'b0; we = 1'b0; addr = '0; size = 2'd2; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);

    // R1 reset state
    check("R1 mask all set", 256'(ent_mask), 256'({N{1'b1}}));
    check("R1 vectors zero", 256'(ent_vector), 256'd0);
    check("R1 dest zero", 256'(ent_dest), 256'd0);
    check("R1 no response", 256'({rsp_valid, err, svc_pulse}), 256'd0);
    access(1'b0, BASE, 2'd2, 32'd0);
    check("R1 selector zero", 256'(rdata), 256'd0);
    access(1'b0, BASE + 32'h10, 2'd2, 32'd0);
    check("R1 id zero", 256'(rdata), 256'd0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].we, BASE + 32'(VEC[i].off), VEC[i].size, VEC[i].wd);
      check($sformatf("vec%0d R12 rsp_valid", i), 256'(rsp_valid), 256'd1);
      check($sformatf("vec%0d err", i), 256'(err), 256'(VEC[i].err));
      check($sformatf("vec%0d rdata", i), 256'(rdata), 256'(VEC[i].rd));
      check($sformatf("vec%0d R7 svc", i), 256'(svc_pulse), 256'(VEC[i].svc));
    end

    // decoded fields at the ports
    check("R5 entry0 vector", 256'(ent_vector[7:0]), 256'h FF);
    check("R5 entry0 dlvmode", 256'(ent_dlvmode[2:0]), 256'd7);
    check("R5 entry0 bits", 256'({ent_dstmode[0], ent_polarity[0], ent_trigger[0], ent_mask[0]}), 256'hF);
    check("R5 entry0 dest", 256'(ent_dest[7:0]), 256'hA5);
    check("R5 entry23 dest", 256'(ent_dest[23*8 +: 8]), 256'h77);
    check("R5 entry23 still masked", 256'(ent_mask[23]), 256'd1);
    check("R6 read-only bits clear", 256'({ent_dlvstat, ent_rirr}), 256'd0);
    check("R11 other entries untouched", 256'(ent_vector[N*8-1:8]), 256'd0);

    // R7 pulse lasts one cycle
    access(1'b1, BASE, 2'd2, 32'h10);
    access(1'b1, BASE + 32'h10, 2'd2, 32'h0000_0020);
    check("R7 pulse high", 256'(svc_pulse), 256'd1);
    @(posedge clk); #1;
    check("R7 pulse one cycle", 256'(svc_pulse), 256'd0);
    check("R5 unmask write", 256'(ent_mask[0]), 256'd0);
    check("R5 new vector", 256'(ent_vector[7:0]), 256'h20);

    // R12 outside region: no response, no change
    access(1'b1, 32'hFEB0_0010, 2'd2, 32'hFFFF_FFFF);
    check("R12 outside write no rsp", 256'({rsp_valid, svc_pulse}), 256'd0);
    check("R12 outside write no effect", 256'(ent_vector[7:0]), 256'h20);
    access(1'b0, 32'hFED0_0000, 2'd2, 32'd0);
    check("R12 outside read no rsp", 256'(rsp_valid), 256'd0);

    // R9 upper half of entry0 low word
    access(1'b0, BASE + 32'h12, 2'd1, 32'd0);
    check("R9 half upper", 256'(rdata), 256'd0);
    access(1'b0, BASE + 32'h10, 2'd1, 32'd0);
    check("R9 half lower", 256'(rdata), 256'h0020);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule